// File: doc/BRIEF.md
# Register-Mapped SHA-1 Hash Engine

This block computes SHA-1 compression on one 512-bit message block at a time and sits behind a small synchronous register port. Each access uses an enable, a write strobe, an 8-bit word address, 32-bit write data and 32-bit read data. Software stores the sixteen words of an already padded block. It then starts the engine in one of two ways. A fresh start reloads the standard SHA-1 initial state. A chained start continues from the digest of the previous block. Software then polls a status word and collects the 160-bit result as five words.

The core runs one round per clock over a 16-word sliding message schedule, 80 rounds per block. The last round also adds the working variables into the digest. A start is triggered by a 0-to-1 change of a control bit between successive control writes, so the usual write-start-then-write-zero sequence launches exactly one operation.

Top module: `hash160_regs`

## Requirements
- R1: After reset the status word (address 0x09) reads 1, meaning bit 0 ready is 1 and bit 1 valid is 0, and every block word and every digest word reads 0.
- R2: Address 0x00 reads 0x48415348 and address 0x01 reads 0x454E4731 (name "HASHENG1", first character in bits 31:24), and address 0x02 reads 0x312E3030 (version "1.00").
- R3: Block words are written and read at 0x10 to 0x1F, where the word at 0x10 is block bits 511:480 and the word at 0x1F is bits 31:0.
- R4: Writing a control word (address 0x08) whose bit 0 (fresh start) rises hashes the block from the standard initial state. The padded message "abc" gives a9993e364706816aba3e25717850c26c9cd0d89d, read as H0 at 0x20 (digest bits 159:128) through H4 at 0x24.
- R5: A rising bit 1 (chained start) hashes the block from the current digest. The 56-character two-block test message gives f4286818c37b27ae0408f581846771484a566572 after a fresh start on block 1 and 84983e441c3bd26ebaae4aa1f95129e5e54670f1 after a chained start on block 2.
- R6: From the cycle after a start is accepted, the status word reads 0 for exactly 80 cycles and then reads 3 (ready and valid).
- R7: A start acts only when its bit is 1 in the written word and was 0 in the previous control write. Writing the same set bit again starts nothing, and status and digest stay unchanged.
- R8: Control writes made while the engine is busy start nothing and leave the running result intact. They still update the history used for edge detection.
- R9: Reads of unmapped addresses (such as 0x03, 0x0A, 0x25, 0xFF) return 0, and the read data is 0 whenever the port is not enabled for a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Access enable for the current cycle |
| acc_wr | input | 1 | 1 for write, 0 for read |
| acc_addr | input | 8 | Word address |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, combinational from the address |

## Verification
The hash is exercised with the one-block "abc" message and with both blocks of the 56-character message, run as fresh, then fresh, then chained, then fresh again. The chained step can only match if the digest carries over from block 1. The final fresh run of "abc" can only match if the initial state really reloads and nothing stale survives. Each run also counts the busy polls, which separates a correct 80-round core from one that is off by a round. Directed tests then repeat a set bit without clearing it, issue control writes while busy, and read unmapped addresses, to check that starts fire only on edges.

// File: rtl/hash160_regs.sv
module hash160_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_en,
  input  logic        acc_wr,
  input  logic [7:0]  acc_addr,
  input  logic [31:0] acc_wdata,
  output logic [31:0] acc_rdata
);
  localparam int NWORD = 16;
  localparam int NDIG  = 5;
  localparam int RW    = 7;
  localparam logic [RW-1:0] LAST = RW'(79);

  localparam logic [7:0] A_ID0  = 8'h00;
  localparam logic [7:0] A_ID1  = 8'h01;
  localparam logic [7:0] A_VER  = 8'h02;
  localparam logic [7:0] A_CTRL = 8'h08;
  localparam logic [7:0] A_STAT = 8'h09;

  localparam logic [31:0] IV0 = 32'h67452301;
  localparam logic [31:0] IV1 = 32'hefcdab89;
  localparam logic [31:0] IV2 = 32'h98badcfe;
  localparam logic [31:0] IV3 = 32'h10325476;
  localparam logic [31:0] IV4 = 32'hc3d2e1f0;

  logic [31:0] blk [NWORD];
  logic [31:0] w   [NWORD];
  logic [31:0] h   [NDIG];
  logic [31:0] a, b, c, d, e;
  logic [RW-1:0] rnd;
  logic busy, valid;
  logic [1:0] ctl_hist;

  wire wr_hit  = acc_en && acc_wr;
  wire ctl_wr  = wr_hit && (acc_addr == A_CTRL);
  wire go_init = ctl_wr && acc_wdata[0] && !ctl_hist[0] && !busy;
  wire go_next = ctl_wr && acc_wdata[1] && !ctl_hist[1] && !busy && !go_init;
  wire go      = go_init || go_next;

  logic [31:0] f, k, temp, wnew, wx;
  always_comb begin
    if (rnd < RW'(20)) begin
      f = (b & c) | (~b & d);
      k = 32'h5a827999;
    end else if (rnd < RW'(40)) begin
      f = b ^ c ^ d;
      k = 32'h6ed9eba1;
    end else if (rnd < RW'(60)) begin
      f = (b & c) | (b & d) | (c & d);
      k = 32'h8f1bbcdc;
    end else begin
      f = b ^ c ^ d;
      k = 32'hca62c1d6;
    end
    temp = {a[26:0], a[31:27]} + f + e + k + w[0];
    wx   = w[13] ^ w[8] ^ w[2] ^ w[0];
    wnew = {wx[30:0], wx[31]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORD; i++) begin
        blk[i] <= '0;
        w[i]   <= '0;
      end
      for (int i = 0; i < NDIG; i++) h[i] <= '0;
      {a, b, c, d, e} <= '0;
      rnd      <= '0;
      busy     <= 1'b0;
      valid    <= 1'b0;
      ctl_hist <= 2'b00;
    end else begin
      if (ctl_wr) ctl_hist <= acc_wdata[1:0];
      if (wr_hit && acc_addr[7:4] == 4'h1) blk[acc_addr[3:0]] <= acc_wdata;
      if (go) begin
        busy  <= 1'b1;
        valid <= 1'b0;
        rnd   <= '0;
        for (int i = 0; i < NWORD; i++) w[i] <= blk[i];
        if (go_init) begin
          h[0] <= IV0; h[1] <= IV1; h[2] <= IV2; h[3] <= IV3; h[4] <= IV4;
          a <= IV0; b <= IV1; c <= IV2; d <= IV3; e <= IV4;
        end else begin
          a <= h[0]; b <= h[1]; c <= h[2]; d <= h[3]; e <= h[4];
        end
      end else if (busy) begin
        for (int i = 0; i < NWORD-1; i++) w[i] <= w[i+1];
        w[NWORD-1] <= wnew;
        e <= d;
        d <= c;
        c <= {b[1:0], b[31:2]};
        b <= a;
        a <= temp;
        rnd <= rnd + RW'(1);
        if (rnd == LAST) begin
          busy  <= 1'b0;
          valid <= 1'b1;
          h[0] <= h[0] + temp;
          h[1] <= h[1] + a;
          h[2] <= h[2] + {b[1:0], b[31:2]};
          h[3] <= h[3] + c;
          h[4] <= h[4] + d;
        end
      end
    end
  end

  always_comb begin
    acc_rdata = '0;
    if (acc_en && !acc_wr) begin
      if (acc_addr[7:4] == 4'h1) acc_rdata = blk[acc_addr[3:0]];
      else begin
        case (acc_addr)
          A_ID0:  acc_rdata = 32'h48415348;
          A_ID1:  acc_rdata = 32'h454e4731;
          A_VER:  acc_rdata = 32'h312e3030;
          A_STAT: acc_rdata = {30'b0, valid, !busy};
          8'h20:  acc_rdata = h[0];
          8'h21:  acc_rdata = h[1];
          8'h22:  acc_rdata = h[2];
          8'h23:  acc_rdata = h[3];
          8'h24:  acc_rdata = h[4];
          default: acc_rdata = '0;
        endcase
      end
    end
  end

  p_start_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (busy && !valid && rnd == '0));
  p_finish_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rnd == LAST) |=> (!busy && valid));
  p_busy_ctl_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rnd != LAST && ctl_wr) |=> (busy && rnd == $past(rnd) + RW'(1)));
  p_digest_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !go) |=> $stable({h[0], h[1], h[2], h[3], h[4]}));
  p_idle_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |-> (acc_rdata == 32'h0));
  p_round_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rnd <= LAST || !busy);
endmodule

// File: tb/sim_hash160_regs.sv
module sim_hash160_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_en = 1'b0, acc_wr = 1'b0;
  logic [7:0] acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic [31:0] rd;
  logic [159:0] dig;
  int n_run = 0, n_fail = 0, cyc = 0;

  always #2.5 clk = ~clk;

  hash160_regs u0 (.clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
                   .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata));

  localparam logic [511:0] VB [4] = '{
    {32'h61626380, 448'h0, 32'h00000018},
    {32'h61626364, 32'h62636465, 32'h63646566, 32'h64656667, 32'h65666768,
     32'h66676869, 32'h6768696a, 32'h68696a6b, 32'h696a6b6c, 32'h6a6b6c6d,
     32'h6b6c6d6e, 32'h6c6d6e6f, 32'h6d6e6f70, 32'h6e6f7071, 32'h80000000, 32'h0},
    {480'h0, 32'h000001c0},
    {32'h61626380, 448'h0, 32'h00000018}};
  localparam logic [1:0] VM [4] = '{2'b01, 2'b01, 2'b10, 2'b01};
  localparam logic [159:0] VD [4] = '{
    160'ha9993e364706816aba3e25717850c26c9cd0d89d,
    160'hf4286818c37b27ae0408f581846771484a566572,
    160'h84983e441c3bd26ebaae4aa1f95129e5e54670f1,
    160'ha9993e364706816aba3e25717850c26c9cd0d89d};

  task automatic chk(input string req, input logic [159:0] act, input logic [159:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] ad, input logic [31:0] dt);
    acc_en = 1'b1; acc_wr = 1'b1; acc_addr = ad; acc_wdata = dt;
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic rdw(input logic [7:0] ad);
    acc_en = 1'b1; acc_wr = 1'b0; acc_addr = ad;
    #1 rd = acc_rdata;
    @(negedge clk);
    acc_en = 1'b0;
  endtask

  task automatic get_digest();
    for (int i = 0; i < 5; i++) begin
      rdw(8'h20 + 8'(i));
      dig[159-32*i -: 32] = rd;
    end
  endtask

  task automatic load(input logic [511:0] blkv);
    for (int i = 0; i < 16; i++) wr(8'h10 + 8'(i), blkv[511-32*i -: 32]);
  endtask

  task automatic poll(output int zeros);
    zeros = 0;
    rdw(8'h09);
    while (rd == 0 && zeros < 300) begin
      zeros++;
      rdw(8'h09);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
    end
  end

  initial begin
    int z;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rdw(8'h09); chk("R1 status", 160'(rd), 160'd1);
    get_digest(); chk("R1 digest", dig, 160'h0);
    rdw(8'h10); chk("R1 block", 160'(rd), 160'h0);

    rdw(8'h00); chk("R2 id0", 160'(rd), 160'h48415348);
    rdw(8'h01); chk("R2 id1", 160'(rd), 160'h454e4731);
    rdw(8'h02); chk("R2 ver", 160'(rd), 160'h312e3030);

    load({32'hdeadbeef, 448'h0, 32'h0badf00d});
    rdw(8'h10); chk("R3 first word", 160'(rd), 160'hdeadbeef);
    rdw(8'h1f); chk("R3 last word", 160'(rd), 160'h0badf00d);

    for (int v = 0; v < 4; v++) begin
      load(VB[v]);
      wr(8'h08, {30'b0, VM[v]});
      poll(z);
      chk("R6 busy cycles", 160'(z), 160'd80);
      chk("R6 done status", 160'(rd), 160'd3);
      wr(8'h08, 32'h0);
      get_digest();
      chk(VM[v][1] ? "R5 chained digest" : "R4 fresh digest", dig, VD[v]);
    end

    load(VB[0]);
    wr(8'h08, 32'h1);
    poll(z);
    wr(8'h08, 32'h1);
    rdw(8'h09); chk("R7 repeated bit no start", 160'(rd), 160'd3);
    get_digest(); chk("R7 digest kept", dig, VD[0]);

    load(VB[2]);
    wr(8'h08, 32'h0);
    wr(8'h08, 32'h1);
    wr(8'h08, 32'h0);
    wr(8'h08, 32'h2);
    poll(z);
    chk("R8 busy writes ignored cycles", 160'(z), 160'd78);
    wr(8'h08, 32'h2);
    rdw(8'h09); chk("R8 history updated while busy", 160'(rd), 160'd3);

    rdw(8'h03); chk("R9 addr 03", 160'(rd), 160'h0);
    rdw(8'h0a); chk("R9 addr 0a", 160'(rd), 160'h0);
    rdw(8'h25); chk("R9 addr 25", 160'(rd), 160'h0);
    rdw(8'hff); chk("R9 addr ff", 160'(rd), 160'h0);
    acc_addr = 8'h00; acc_en = 1'b0;
    #1 chk("R9 disabled read", 160'(acc_rdata), 160'h0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule